// File: doc/BRIEF.md
# Next-PC and Breakpoint Trap Unit

This block holds the program counter of a small 32-bit RISC core and works out its next value from the instruction that retires each cycle. It recognises two instructions: an unconditional PC-relative branch and a debug breakpoint. Every other instruction simply steps the PC to the next word. A branch adds a sign-extended byte offset to the address of the following instruction. If that target is not word-aligned, the branch is refused and a one-cycle fault flag is raised.

A breakpoint saves the return address and the full incoming status word into two dedicated registers. It then clears the interrupt-enable and user-mode bits of the live status and jumps to a fixed handler address.

The core presents an instruction word with a valid strobe, together with its current status word. The block returns the registered PC and status, the saved break address and break status, and the misalignment flag with the faulting address. Both the handler address and the reset vector are parameters.

Top module: `pc_trap_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC loads `RESET_VEC`. The status, saved break address, saved break status, fault flag and fault address are all cleared.
- R2: A valid word whose bits 5:0 equal 0x06 and whose bits 31:22 are all zero is a branch. Its 16-bit immediate sits in bits 21:6. The target is PC+4 plus the sign-extended immediate, and the PC takes the target on the next edge.
- R3: A branch immediate with bit 15 set is a negative offset, so the branch goes backward from PC+4.
- R4: A branch whose target has either of its two low bits set leaves the PC unchanged. For exactly one cycle it raises `misalign_o` with `fault_addr_o` equal to the target. When the flag is low, `fault_addr_o` reads zero.
- R5: A word with opcode 0x06 but any of bits 31:22 set is not a branch, so the PC advances by 4.
- R6: A valid word with opcode 0x3A in bits 5:0 and function code 0x34 in bits 16:11 is a breakpoint. The saved break address becomes PC+4 and the PC becomes `BREAK_VEC`.
- R7: On a breakpoint, the saved break status takes the whole of `status_i`. The live status becomes `status_i` with bit 0 (interrupt enable) and bit 1 (user mode) cleared.
- R8: The 5-bit field in bits 10:6 of a breakpoint word has no effect on any output.
- R9: Any other valid word advances the PC by 4 and loads the live status from `status_i`. A branch, aligned or not, also loads the live status from `status_i`.
- R10: While `instr_valid_i` is low, the PC, status and both saved registers keep their values, and `misalign_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Instruction word is retiring this cycle |
| instr_i | input | 32 | Instruction word |
| status_i | input | STAT_W | Core status word before this instruction |
| pc_o | output | ADDR_W | Registered program counter |
| status_o | output | STAT_W | Registered status after this instruction |
| brk_addr_o | output | ADDR_W | Saved return address of the last breakpoint |
| brk_stat_o | output | STAT_W | Saved status of the last breakpoint |
| misalign_o | output | 1 | One-cycle misaligned-branch fault |
| fault_addr_o | output | ADDR_W | Refused target while `misalign_o` is high, else zero |

## Verification
Every result is produced by a single register stage. An instruction presented before clock edge N shows its PC, status, saved registers and fault flag just after edge N, and the fault flag drops again after edge N+1. The driver sets inputs on the falling edge and pushes one expected record per cycle into a queue. The monitor pops one record a quarter period after each rising edge, so every comparison lands in the cycle its result is due. The cycle after a misaligned branch and the cycles with the strobe low get their own records, which checks both the one-cycle pulse and the hold behaviour.

// File: rtl/pctrap_pkg.sv
package pctrap_pkg;
    localparam int unsigned INSTR_W = 32;

    localparam logic [5:0] OPC_JUMP_REL = 6'h06;
    localparam logic [5:0] OPC_REG_FMT  = 6'h3A;
    localparam logic [5:0] FUNC_TRAP    = 6'h34;

    typedef enum logic [1:0] {
        KIND_SEQ    = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_BREAK  = 2'd2
    } instr_kind_e;
endpackage

// File: rtl/pctrap_decode.sv
module pctrap_decode
    import pctrap_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output instr_kind_e        kind_o,
    output logic [15:0]        imm16_o
);
    logic [5:0] opcode;
    logic [5:0] func;
    logic       upper_clear;

    always_comb begin
        opcode      = instr_i[5:0];
        func        = instr_i[16:11];
        upper_clear = (instr_i[31:22] == 10'd0);
        imm16_o     = instr_i[21:6];
        if (opcode == OPC_JUMP_REL && upper_clear) begin
            kind_o = KIND_BRANCH;
        end else if (opcode == OPC_REG_FMT && func == FUNC_TRAP) begin
            kind_o = KIND_BREAK;
        end else begin
            kind_o = KIND_SEQ;
        end
    end
endmodule

// File: rtl/pctrap_target.sv
module pctrap_target #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [15:0]       imm16_i,
    output logic [ADDR_W-1:0] seq_pc_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              misaligned_o
);
    localparam int unsigned EXT_W = ADDR_W - 16;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset       = {{EXT_W{imm16_i[15]}}, imm16_i};
        seq_pc_o     = pc_i + ADDR_W'(4);
        target_o     = seq_pc_o + offset;
        misaligned_o = (target_o[1:0] != 2'b00);
    end
endmodule

// File: rtl/pc_trap_unit.sv
module pc_trap_unit
    import pctrap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned STAT_W    = 32,
    parameter int unsigned PIE_BIT   = 0,
    parameter int unsigned U_BIT     = 1,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] BREAK_VEC = 32'h0000_0120
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid_i,
    input  logic [31:0]        instr_i,
    input  logic [STAT_W-1:0]  status_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [STAT_W-1:0]  status_o,
    output logic [ADDR_W-1:0]  brk_addr_o,
    output logic [STAT_W-1:0]  brk_stat_o,
    output logic               misalign_o,
    output logic [ADDR_W-1:0]  fault_addr_o
);
    localparam logic [STAT_W-1:0] TRAP_CLR_MASK =
        (STAT_W'(1) << PIE_BIT) | (STAT_W'(1) << U_BIT);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [STAT_W-1:0] status;
        logic [ADDR_W-1:0] brk_addr;
        logic [STAT_W-1:0] brk_stat;
        logic              misalign;
        logic [ADDR_W-1:0] fault_addr;
    } trap_state_t;

    trap_state_t st_d, st_q;

    instr_kind_e       kind;
    logic [15:0]       imm16;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] br_target;
    logic              br_misaligned;

    pctrap_decode u_decode (
        .instr_i (instr_i),
        .kind_o  (kind),
        .imm16_o (imm16)
    );

    pctrap_target #(.ADDR_W(ADDR_W)) u_target (
        .pc_i         (st_q.pc),
        .imm16_i      (imm16),
        .seq_pc_o     (seq_pc),
        .target_o     (br_target),
        .misaligned_o (br_misaligned)
    );

    always_comb begin
        st_d            = st_q;
        st_d.misalign   = 1'b0;
        st_d.fault_addr = '0;
        if (instr_valid_i) begin
            unique case (kind)
                KIND_BRANCH: begin
                    st_d.status = status_i;
                    if (br_misaligned) begin
                        st_d.misalign   = 1'b1;
                        st_d.fault_addr = br_target;
                    end else begin
                        st_d.pc = br_target;
                    end
                end
                KIND_BREAK: begin
                    st_d.brk_stat = status_i;
                    st_d.brk_addr = seq_pc;
                    st_d.status   = status_i & ~TRAP_CLR_MASK;
                    st_d.pc       = BREAK_VEC;
                end
                default: begin
                    st_d.status = status_i;
                    st_d.pc     = seq_pc;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc         <= RESET_VEC;
            st_q.status     <= '0;
            st_q.brk_addr   <= '0;
            st_q.brk_stat   <= '0;
            st_q.misalign   <= 1'b0;
            st_q.fault_addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o         = st_q.pc;
    assign status_o     = st_q.status;
    assign brk_addr_o   = st_q.brk_addr;
    assign brk_stat_o   = st_q.brk_stat;
    assign misalign_o   = st_q.misalign;
    assign fault_addr_o = st_q.fault_addr;

    // R10: an idle cycle keeps every architectural register and no fault is raised
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !instr_valid_i |=> ($stable(pc_o) && $stable(status_o) && $stable(brk_addr_o)
                            && $stable(brk_stat_o) && !misalign_o));

    // R6: a breakpoint lands on the handler and saves the following address
    p_break_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && kind == KIND_BREAK) |=>
            (pc_o == BREAK_VEC && brk_addr_o == $past(pc_o) + ADDR_W'(4)));

    // R7: trap entry leaves interrupt enable and user mode cleared
    p_break_status_r7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && kind == KIND_BREAK) |=>
            (status_o[PIE_BIT] == 1'b0 && status_o[U_BIT] == 1'b0
             && brk_stat_o == $past(status_i)));

    // R4: a raised fault means the PC did not move and the address is unaligned
    p_fault_pc_r4: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> ($stable(pc_o) && fault_addr_o[1:0] != 2'b00));

    // R4: the fault flag is a single-cycle pulse
    p_fault_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        misalign_o |=> !misalign_o);

    // R2: an aligned branch moves the PC off the sequential path only through the target
    p_branch_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && kind == KIND_BRANCH && !br_misaligned) |=>
            (pc_o == $past(br_target) && !misalign_o));
endmodule

// File: tb/tb_pc_trap_unit.sv
module tb_pc_trap_unit;
    localparam logic [31:0] RV = 32'h0000_1000;
    localparam logic [31:0] BV = 32'h0000_0120;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid_i;
    logic [31:0] instr_i;
    logic [31:0] status_i;
    logic [31:0] pc_o, status_o, brk_addr_o, brk_stat_o, fault_addr_o;
    logic        misalign_o;

    always #10 clk = ~clk;

    pc_trap_unit #(.RESET_VEC(RV), .BREAK_VEC(BV)) dut (
        .clk(clk), .rst(rst), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
        .status_i(status_i), .pc_o(pc_o), .status_o(status_o),
        .brk_addr_o(brk_addr_o), .brk_stat_o(brk_stat_o),
        .misalign_o(misalign_o), .fault_addr_o(fault_addr_o)
    );

    typedef struct {
        logic [31:0] pc, st, ba, bs, fa;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_pc, m_st, m_ba, m_bs;

    function automatic logic [31:0] mk_br(input logic [15:0] imm);
        return {10'd0, imm, 6'h06};
    endfunction

    function automatic logic [31:0] mk_brk(input logic [4:0] imm5);
        return {15'd0, 6'h34, imm5, 6'h3A};
    endfunction

    task automatic push(input logic [31:0] fa, input logic mis, input string tag);
        exp_t e;
        e.pc = m_pc; e.st = m_st; e.ba = m_ba; e.bs = m_bs;
        e.fa = fa; e.mis = mis; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; instr_valid_i = 1'b0; instr_i = '0; status_i = 32'hFFFF_FFFF;
        m_pc = RV; m_st = '0; m_ba = '0; m_bs = '0;
        push('0, 1'b0, tag);
    endtask

    // kind: 0 sequential, 1 branch, 2 breakpoint (bench-side classification)
    task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] st,
                        input int kind, input string tag);
        logic [31:0] tgt;
        logic [31:0] fa;
        logic        mis;
        @(negedge clk);
        rst = 1'b0; instr_valid_i = v; instr_i = ins; status_i = st;
        fa = '0; mis = 1'b0;
        if (v) begin
            if (kind == 1) begin
                tgt = m_pc + 32'd4 + {{16{ins[21]}}, ins[21:6]};
                m_st = st;
                if (tgt[1:0] != 2'b00) begin mis = 1'b1; fa = tgt; end
                else m_pc = tgt;
            end else if (kind == 2) begin
                m_bs = st; m_ba = m_pc + 32'd4; m_st = st & ~32'h3; m_pc = BV;
            end else begin
                m_st = st; m_pc = m_pc + 32'd4;
            end
        end
        push(fa, mis, tag);
    endtask

    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (pc_o !== e.pc || status_o !== e.st || brk_addr_o !== e.ba ||
                brk_stat_o !== e.bs || misalign_o !== e.mis || fault_addr_o !== e.fa) begin
                bad++;
                $display("FAIL %s: got pc=%h st=%h ba=%h bs=%h mis=%b fa=%h exp pc=%h st=%h ba=%h bs=%h mis=%b fa=%h",
                         e.tag, pc_o, status_o, brk_addr_o, brk_stat_o, misalign_o, fault_addr_o,
                         e.pc, e.st, e.ba, e.bs, e.mis, e.fa);
            end
        end
    end

    initial begin
        do_reset("R1 reset state");
        do_reset("R1 reset held");
        step(1'b1, 32'h0000_0000, 32'h0000_0003, 0, "R9 plain instruction");
        step(1'b1, 32'h1234_5601, 32'h0000_0001, 0, "R9 other opcode");
        step(1'b1, mk_br(16'h0008), 32'h0000_0002, 1, "R2 forward branch");
        step(1'b1, mk_br(16'hFFF0), 32'h0000_0002, 1, "R3 backward branch");
        step(1'b1, mk_br(16'h8000), 32'h0000_0000, 1, "R3 largest negative offset");
        step(1'b1, mk_br(16'h7FFC), 32'h0000_0000, 1, "R2 largest positive offset");
        step(1'b1, mk_br(16'h0002), 32'h0000_0007, 1, "R4 misaligned by 2");
        step(1'b1, 32'h0000_0000, 32'h0000_0000, 0, "R4 flag drops after one cycle");
        step(1'b1, mk_br(16'hFFFD), 32'h0000_0000, 1, "R4 misaligned negative");
        step(1'b0, mk_br(16'h0040), 32'h0000_00AA, 1, "R10 idle branch word");
        step(1'b1, mk_br(16'h0040) | 32'h0200_0000, 32'h0000_0000, 0, "R5 upper bits set");
        step(1'b1, mk_brk(5'd0), 32'h0000_00F3, 2, "R6 R7 breakpoint imm 0");
        step(1'b0, mk_brk(5'd0), 32'h0000_0055, 2, "R10 idle breakpoint word");
        step(1'b1, 32'h0000_0000, 32'h8000_0003, 0, "R9 after handler entry");
        step(1'b1, mk_brk(5'd31), 32'h8000_0003, 2, "R8 breakpoint imm 31");
        step(1'b1, mk_brk(5'd31), 32'h0000_0001, 2, "R7 only enable bit set");
        do_reset("R1 reset after traffic");
        step(1'b0, 32'h0000_0000, 32'h0000_0000, 0, "R10 idle after reset");
        @(negedge clk);
        instr_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        #8;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule